// File: doc/BRIEF.md
# SHA-1 Hash Engine with Double-Buffered Register Interface

This block puts an iterative SHA-1 compression engine behind a plain 32-bit register port with chip-select, write-enable and a byte address. The host writes sixteen 32-bit message words into holding registers, then starts the engine by writing the control register. One control bit hashes the block from the standard initial hash value. The other bit chains from the digest that the previous block left behind. When the engine finishes, it hands its five-word result to a separate set of digest registers, which the host reads back.

The engine copies the holding registers at the moment it accepts a command. From that point the host may overwrite them with the next block while the current one is still being hashed, so loading and hashing overlap. The engine runs one round per clock. Its controller has three states:

- `CORE_IDLE` → `CORE_ROUND`: taken when a command arrives; this transition loads the working variables and the message window.
- `CORE_ROUND` → `CORE_ROUND`: taken for the first 79 rounds.
- `CORE_ROUND` → `CORE_FINAL`: taken after the 80th round.
- `CORE_FINAL` → `CORE_IDLE`: adds the working variables into the chaining value and raises a one-cycle completion strobe.

Top module: `sha1_mmio`

## Requirements
- R1: The message holding registers sit at byte addresses 0x10 to 0x1F, one 32-bit word per address. The word at 0x10 is the most significant (first) word of the block. Each register reads back the last value written to it.
- R2: Writing the control register at 0x08 with bit 0 set hashes the held block, starting from the initial value 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0. The digest then reads back at 0x20 to 0x24, with H0 at 0x20.
- R3: Writing the control register with only bit 1 set hashes the held block, starting from the digest of the previous block.
- R4: The status register at 0x09 reports engine-idle in bit 0 and digest-valid in bit 1; all other bits read zero. Bit 0 is low while a block is being hashed. Bit 1 is set at completion and cleared when the engine accepts a new command.
- R5: The control bits clear themselves. A control write starts the engine at most once, and address 0x08 reads as zero.
- R6: The digest registers read zero after reset. They change only when the engine signals completion, so during hashing they keep the previous result.
- R7: Message words written while a block is being hashed do not alter that block's digest. They are the words used by the next command.
- R8: A control write that arrives while the engine is busy is discarded. It neither restarts the engine nor starts a later run.
- R9: Reads from addresses not listed here return zero. Writes to the status and digest registers change nothing.
- R10: Digest-valid reads 1 no later than 84 clock cycles after the clock edge that captures the control write.
- R11: A control write with both bits set acts as a plain initial-value hash (bit 0 wins).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register access select |
| we | input | 1 | 1 = write, 0 = read (qualified by cs) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as a read access, zero when not reading |

## Verification
The bench models the compression function arithmetically. It checks one known single-block digest, and it checks a chain of generated blocks that are fed in with the chaining command, so a design that ignored the previous digest, or reloaded the initial value, would give wrong words. It overwrites the entire holding bank and issues a stray start while a block is in flight. A design that read its block from the holding registers after accepting the command would produce a corrupted digest. A design that queued the stray start would drop digest-valid, or fail to return to idle, during the long wait that follows. It also writes both control bits at once, writes to the read-only registers and reads unmapped addresses. A design with the wrong priority, with writable status or digest registers, or with aliased decoding would show a mismatch at the port.

// File: rtl/sha1w_pkg.sv
package sha1w_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int DIG_WORDS = 5;
    localparam int N_ROUNDS  = 80;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        CORE_IDLE,
        CORE_ROUND,
        CORE_FINAL
    } core_state_e;

    localparam logic [DIG_WORDS*WORD_W-1:0] SHA1_IV = {
        32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0
    };

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Round-dependent boolean mixing function
    function automatic word_t mix_fn(input logic [6:0] t, input word_t b,
                                     input word_t c, input word_t d);
        if (t < 7'd20)      return (b & c) | (~b & d);
        else if (t < 7'd40) return b ^ c ^ d;
        else if (t < 7'd60) return (b & c) | (b & d) | (c & d);
        else                return b ^ c ^ d;
    endfunction

    function automatic word_t round_k(input logic [6:0] t);
        if (t < 7'd20)      return 32'h5A827999;
        else if (t < 7'd40) return 32'h6ED9EBA1;
        else if (t < 7'd60) return 32'h8F1BBCDC;
        else                return 32'hCA62C1D6;
    endfunction
endpackage

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
    import sha1w_pkg::*;
#(
    parameter int DEPTH = BLK_WORDS
) (
    input  logic                    clk,
    input  logic                    load,
    input  logic                    advance,
    input  logic [DEPTH*WORD_W-1:0] block,
    output word_t                   w_cur
);
    // win[0] holds the schedule word for the current round
    word_t win [DEPTH];

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < DEPTH; i++)
                win[i] <= block[(DEPTH-1-i)*WORD_W +: WORD_W];
        end else if (advance) begin
            for (int i = 0; i < DEPTH-1; i++)
                win[i] <= win[i+1];
            win[DEPTH-1] <= rotl(win[13] ^ win[8] ^ win[2] ^ win[0], 1);
        end
    end

    assign w_cur = win[0];
endmodule

// File: rtl/sha1_round_core.sv
module sha1_round_core
    import sha1w_pkg::*;
#(
    parameter int ROUNDS = N_ROUNDS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_init,
    input  logic                        cmd_next,
    input  logic [BLK_WORDS*WORD_W-1:0] block,
    output logic                        ready,
    output logic                        done,
    output logic [DIG_WORDS*WORD_W-1:0] digest
);
    localparam int RND_W = $clog2(ROUNDS);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    core_state_e state_q, state_d;
    logic [RND_W-1:0] rnd_q;
    word_t a_q, b_q, c_q, d_q, e_q;
    logic [DIG_WORDS*WORD_W-1:0] h_q;
    word_t w_cur, temp;
    logic  start;

    assign start = cmd_init | cmd_next;
    assign ready = (state_q == CORE_IDLE);

    sha1_msg_window #(.DEPTH(BLK_WORDS)) u_window (
        .clk    (clk),
        .load   (ready & start),
        .advance(state_q == CORE_ROUND),
        .block  (block),
        .w_cur  (w_cur)
    );

    assign temp = rotl(a_q, 5) + mix_fn(7'(rnd_q), b_q, c_q, d_q) + e_q
                + round_k(7'(rnd_q)) + w_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CORE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_IDLE:  if (start) state_d = CORE_ROUND;
            CORE_ROUND: if (rnd_q == LAST_RND) state_d = CORE_FINAL;
            CORE_FINAL: state_d = CORE_IDLE;
            default:    state_d = CORE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_q <= '0;
            done  <= 1'b0;
            h_q   <= SHA1_IV;
            {a_q, b_q, c_q, d_q, e_q} <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                CORE_IDLE: begin
                    if (start) begin
                        rnd_q <= '0;
                        if (cmd_init) begin
                            h_q <= SHA1_IV;
                            {a_q, b_q, c_q, d_q, e_q} <= SHA1_IV;
                        end else begin
                            {a_q, b_q, c_q, d_q, e_q} <= h_q;
                        end
                    end
                end
                CORE_ROUND: begin
                    rnd_q <= rnd_q + 1'b1;
                    a_q   <= temp;
                    b_q   <= a_q;
                    c_q   <= rotl(b_q, 30);
                    d_q   <= c_q;
                    e_q   <= d_q;
                end
                CORE_FINAL: begin
                    h_q  <= {h_q[159:128] + a_q, h_q[127:96] + b_q,
                             h_q[95:64] + c_q, h_q[63:32] + d_q,
                             h_q[31:0] + e_q};
                    done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign digest = h_q;
endmodule

// File: rtl/sha1_mmio.sv
module sha1_mmio
    import sha1w_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(8'h09);
    localparam logic [ADDR_W-1:0] A_BLK    = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] A_DIG    = ADDR_W'(8'h20);
    localparam int BLK_IDX_W = $clog2(BLK_WORDS);
    localparam int DIG_IDX_W = $clog2(DIG_WORDS);

    logic [0:BLK_WORDS-1][WORD_W-1:0] blk_q;
    logic [0:DIG_WORDS-1][WORD_W-1:0] dig_q;
    logic [DIG_WORDS*WORD_W-1:0]      core_digest;
    logic go_init_q, go_next_q, valid_q;
    logic core_ready, core_done, accepted, wr;
    logic [ADDR_W-1:0] blk_off, dig_off;

    assign wr       = cs & we;
    assign blk_off  = addr - A_BLK;
    assign dig_off  = addr - A_DIG;
    assign accepted = core_ready & (go_init_q | go_next_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_init_q <= 1'b0;
            go_next_q <= 1'b0;
        end else begin
            go_init_q <= wr && (addr == A_CTRL) && wdata[0];
            go_next_q <= wr && (addr == A_CTRL) && wdata[1] && !wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (wr && addr >= A_BLK && addr < A_BLK + ADDR_W'(BLK_WORDS)) begin
            blk_q[blk_off[BLK_IDX_W-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (core_done) dig_q <= core_digest;
            if (accepted)       valid_q <= 1'b0;
            else if (core_done) valid_q <= 1'b1;
        end
    end

    sha1_round_core #(.ROUNDS(N_ROUNDS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_init(go_init_q),
        .cmd_next(go_next_q),
        .block   (blk_q),
        .ready   (core_ready),
        .done    (core_done),
        .digest  (core_digest)
    );

    always_comb begin
        rdata = '0;
        if (cs && !we) begin
            if (addr == A_STATUS)
                rdata = {30'b0, valid_q, core_ready};
            else if (addr >= A_BLK && addr < A_BLK + ADDR_W'(BLK_WORDS))
                rdata = blk_q[blk_off[BLK_IDX_W-1:0]];
            else if (addr >= A_DIG && addr < A_DIG + ADDR_W'(DIG_WORDS))
                rdata = dig_q[dig_off[DIG_IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/sha1_mmio_checks.sv
module sha1_mmio_checks (
    input logic         clk,
    input logic         rst_n,
    input logic         go_any,
    input logic         core_ready,
    input logic         core_done,
    input logic         valid_q,
    input logic [159:0] dig_flat
);
    p_accept_drops_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_any && core_ready) |=> !core_ready);

    p_accept_clears_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_any && core_ready) |=> !valid_q);

    p_digest_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> $stable(dig_flat));

    p_done_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> core_ready);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);
endmodule

bind sha1_mmio sha1_mmio_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_any    (go_init_q | go_next_q),
    .core_ready(core_ready),
    .core_done (core_done),
    .valid_q   (valid_q),
    .dig_flat  (dig_q)
);

// File: tb/sha1_mmio_test.sv
`timescale 1ns/1ps
module sha1_mmio_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [159:0] IV = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                   32'h10325476, 32'hC3D2E1F0};

    sha1_mmio uut (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
                   .addr(addr), .wdata(wdata), .rdata(rdata));

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog R10: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] ref_hash(input logic [159:0] h, input logic [511:0] m);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = m[511 - 32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        {a, b, c, d, e} = h;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    function automatic logic [511:0] gen_block(input int seed);
        logic [511:0] r;
        for (int i = 0; i < 16; i++)
            r[511 - 32*i -: 32] = 32'(32'h9E3779B9 * (seed * 16 + i + 1)) ^ {seed[7:0], 8'(i), 16'hA5C3};
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk);
        #1 cs = 1'b0;
    endtask

    task automatic load_block(input logic [511:0] m);
        for (int i = 0; i < 16; i++) bus_wr(8'h10 + 8'(i), m[511 - 32*i -: 32]);
    endtask

    task automatic check_digest(input string req, input logic [159:0] exp);
        logic [31:0] v;
        for (int i = 0; i < 5; i++) begin
            bus_rd(8'h20 + 8'(i), v);
            chk(req, v, exp[159 - 32*i -: 32]);
        end
    endtask

    // Issues a control write, then polls status; returns cycles until valid
    task automatic run_cmd(input logic [31:0] ctl, output int cycles);
        logic [31:0] s;
        cycles = 0;
        bus_wr(8'h08, ctl);
        do begin
            bus_rd(8'h09, s);
            cycles++;
        end while (!s[1] && cycles < 500);
    endtask

    initial begin
        logic [31:0] v;
        logic [159:0] h, hx;
        logic [511:0] abc, bx, by;
        int cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        bus_rd(8'h09, v); chk("R4 reset status", v, 32'h1);
        check_digest("R6 reset digest", 160'h0);
        bus_rd(8'h08, v); chk("R5 ctrl reads zero", v, 32'h0);
        bus_rd(8'h00, v); chk("R9 unmapped 0x00", v, 32'h0);
        bus_rd(8'h25, v); chk("R9 unmapped 0x25", v, 32'h0);
        bus_rd(8'hFF, v); chk("R9 unmapped 0xFF", v, 32'h0);

        // Known single-block message "abc"
        abc = '0;
        abc[511:480] = 32'h61626380;
        abc[31:0]    = 32'h00000018;
        load_block(abc);
        for (int i = 0; i < 16; i++) begin
            bus_rd(8'h10 + 8'(i), v);
            chk("R1 block readback", v, abc[511 - 32*i -: 32]);
        end
        bus_wr(8'h08, 32'h1);
        bus_rd(8'h09, v); chk("R4 busy status", v, 32'h0);
        cyc = 1;
        do begin bus_rd(8'h09, v); cyc++; end while (!v[1] && cyc < 500);
        chk("R10 latency bound", 32'(cyc <= 84), 32'h1);
        chk("R4 done status", v, 32'h3);
        check_digest("R2 abc digest", 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
        check_digest("R2 model digest", ref_hash(IV, abc));
        bus_rd(8'h08, v); chk("R5 ctrl self-clears", v, 32'h0);

        // Chained blocks
        h = ref_hash(IV, abc);
        for (int s = 1; s <= 5; s++) begin
            bx = gen_block(s);
            load_block(bx);
            run_cmd(32'h2, cyc);
            chk("R10 chained latency", 32'(cyc <= 84), 32'h1);
            h = ref_hash(h, bx);
            check_digest("R3 chained digest", h);
        end

        // Preload during processing, stray start while busy
        bx = gen_block(11);
        by = gen_block(12);
        load_block(bx);
        bus_wr(8'h08, 32'h1);
        load_block(by);
        bus_rd(8'h09, v); chk("R4 busy during preload", v, 32'h0);
        check_digest("R6 digest held while busy", h);
        bus_wr(8'h08, 32'h1);
        cyc = 0;
        do begin bus_rd(8'h09, v); cyc++; end while (!v[1] && cyc < 500);
        hx = ref_hash(IV, bx);
        check_digest("R7 preload isolated", hx);
        repeat (120) @(negedge clk);
        bus_rd(8'h09, v); chk("R8 busy command discarded", v, 32'h3);
        check_digest("R8 digest unchanged", hx);
        run_cmd(32'h2, cyc);
        check_digest("R7 preloaded block used", ref_hash(hx, by));

        // Read-only registers
        bus_wr(8'h09, 32'h0);
        bus_rd(8'h09, v); chk("R9 status write ignored", v, 32'h3);
        for (int i = 0; i < 5; i++) bus_wr(8'h20 + 8'(i), 32'hDEADBEEF);
        check_digest("R9 digest write ignored", ref_hash(hx, by));
        bus_wr(8'h30, 32'h12345678);
        bus_rd(8'h30, v); chk("R9 unmapped write", v, 32'h0);

        // Both control bits set: initial-value hash
        run_cmd(32'h3, cyc);
        check_digest("R11 init priority", ref_hash(IV, by));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule